// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is an I2C bus master that software steers one bus action at a time through a small register port. A control register holds an enable bit and two qualifier bits, start and stop. Every write to the transmit byte register launches exactly one action, chosen from the qualifiers held at that moment:

- a START condition followed by the written byte;
- the written byte alone;
- a STOP condition, for which the written value is a dummy.

A complete write transaction to a serial memory is therefore a sequence of register writes:

1. START with the device address.
2. The word address as a plain byte.
3. The payload as a plain byte.
4. STOP with a dummy byte.

Software polls the status register between the actions.

The block drives SCL and SDA as open-drain lines. Each output means "pull the line low", and a released line floats high through the board's pull-up. The bus half-period comes from a divider register counted in system clock cycles. At the end of every byte the master releases SDA for a ninth clock and samples whether the slave pulled it low. Between a byte and the next action the master holds SCL low. After a STOP it releases both lines.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control register reads 0, the status register reads done=1 and ack=0, the transmit byte register reads 0, the divider reads its reset parameter value, and both `scl_oe` and `sda_oe` are 0 (lines released).
- R2: A transmit byte write that is accepted clears the done flag (status bit 0) in the next cycle. Done returns to 1 on the clock edge that ends the action. An action lasts a whole number of half-periods.
- R3: With start=1 and stop=0, the action takes 22 half-periods: SDA released, SCL released, SDA pulled low while SCL is high, then the byte sequence of R4.
- R4: A byte action without START takes 19 half-periods. SCL is first pulled low for one half-period. Then come 8 data bits, most significant first, each as one low and one high SCL half-period. Then a ninth clock with SDA released. SDA changes only while SCL is low. After the byte, SCL stays pulled low and SDA stays released.
- R5: Status bit 1 (ack) becomes 1 when SDA is low at the edge that ends the ninth clock's high half-period, and 0 otherwise. It updates on the same edge that sets done. It keeps its value through STOP actions until the next byte completes.
- R6: With stop=1, the action takes 4 half-periods: SCL pulled low, SDA pulled low, SCL released, then SDA released while SCL is high. The written data has no effect on the lines, and both lines end released.
- R7: When start and stop are both set, the action is a STOP as in R6.
- R8: The half-period equals the divider register value in system clock cycles. Divider values below 4 act as 4.
- R9: A transmit byte write while enable is 0, or while an action is in progress, launches nothing. It leaves done, ack, the lines and the running action's length unchanged.
- R10: The register map is as follows. Unused bits read 0, and writes to status are ignored.

  | Address | Register | Contents |
  |---|---|---|
  | 0 | control | bit 0 enable, bit 1 start, bit 2 stop |
  | 1 | status | bit 0 done, bit 1 ack |
  | 2 | transmit byte | last value written, bits 7..0 |
  | 3 | divider | 16 bits |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` (combinational) |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the block with a divider reset value of 5, so the first actions run at a five-cycle half-period. It then reprograms the divider to 2, which is clamped to 4, and to 6. This exercises both the clamp and a plain non-minimum setting while keeping each 22-half-period action near a hundred cycles. With these short periods, a single run covers a START from an idle bus, a repeated START from a held bus, plain bytes with and without an acknowledging slave, dummy-data STOPs and the combined start-plus-stop case. The line drives and every register readback are compared against the reference on each cycle.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int DIV_W    = 16;
    localparam int HALF_MIN = 4;

    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_TXB  = 2'd2;
    localparam logic [1:0] ADR_DIV  = 2'd3;

    typedef struct packed {
        logic stop;
        logic start;
        logic en;
    } ctrl_t;

    // 1 in a field means that line is pulled low
    typedef struct packed {
        logic scl;
        logic sda;
    } drive_t;

    typedef enum logic [1:0] {
        ACT_BYTE  = 2'd0,
        ACT_START = 2'd1,
        ACT_STOP  = 2'd2
    } act_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ST_REL_SDA,
        PH_ST_REL_SCL,
        PH_ST_FALL,
        PH_PREP,
        PH_BIT_LO,
        PH_BIT_HI,
        PH_ACK_LO,
        PH_ACK_HI,
        PH_SP_SCL_LO,
        PH_SP_SDA_LO,
        PH_SP_SCL_HI,
        PH_SP_RISE
    } phase_e;

    function automatic logic [DIV_W-1:0] clamp_half(input logic [DIV_W-1:0] v);
        return (v < DIV_W'(HALF_MIN)) ? DIV_W'(HALF_MIN) : v;
    endfunction

    function automatic act_e pick_action(input ctrl_t c);
        if (c.stop)
            return ACT_STOP;
        else if (c.start)
            return ACT_START;
        else
            return ACT_BYTE;
    endfunction

endpackage

// File: rtl/i2cm_regs.sv
module i2cm_regs
    import i2cm_pkg::*;
#(
    parameter int               REG_W     = 16,
    parameter int               BYTE_W    = 8,
    parameter logic [DIV_W-1:0] DIV_RESET = 16'd8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic              done,
    input  logic              ack,
    output logic              launch,
    output act_e              action,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [DIV_W-1:0]  half
);

    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] txb_q;
    logic [DIV_W-1:0]  div_q;
    logic              tx_hit;

    assign tx_hit  = wr && (addr == ADR_TXB);
    assign launch  = tx_hit && ctrl_q.en && done;
    assign action  = pick_action(ctrl_q);
    assign tx_byte = wdata[BYTE_W-1:0];
    assign half    = clamp_half(div_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            txb_q  <= '0;
            div_q  <= DIV_RESET;
        end else if (wr) begin
            case (addr)
                ADR_CTRL: ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
                ADR_TXB:  txb_q  <= wdata[BYTE_W-1:0];
                ADR_DIV:  div_q  <= wdata[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADR_CTRL: rdata = REG_W'(ctrl_q);
            ADR_STAT: rdata = REG_W'({ack, done});
            ADR_TXB:  rdata = REG_W'(txb_q);
            default:  rdata = REG_W'(div_q);
        endcase
    end

    // R9: a byte write with enable clear must leave the done flag alone
    a_r9_disabled_write_inert: assert property (@(posedge clk) disable iff (rst)
        (tx_hit && !ctrl_q.en && done) |=> done);

endmodule

// File: rtl/i2cm_timer.sv
module i2cm_timer
    import i2cm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load || tick)
            cnt_q <= half - 1'b1;
        else if (run)
            cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  act_e              action,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              sda_i,
    output logic              busy,
    output logic              done,
    output logic              ack,
    output logic              scl_oe,
    output logic              sda_oe
);

    localparam int CNT_W = (BYTE_W > 2) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    phase_e            ph_q, ph_n;
    logic [BYTE_W-1:0] sh_q, sh_n;
    logic [CNT_W-1:0]  bits_q, bits_n;
    drive_t            drv_q, drv_n;
    logic              finish;

    assign busy   = (ph_q != PH_IDLE);
    assign finish = busy && (ph_n == PH_IDLE);
    assign scl_oe = drv_q.scl;
    assign sda_oe = drv_q.sda;

    // phase sequencing
    always_comb begin
        ph_n   = ph_q;
        sh_n   = sh_q;
        bits_n = bits_q;
        if (ph_q == PH_IDLE) begin
            if (launch) begin
                sh_n = tx_byte;
                case (action)
                    ACT_STOP:  ph_n = PH_SP_SCL_LO;
                    ACT_START: ph_n = PH_ST_REL_SDA;
                    default:   ph_n = PH_PREP;
                endcase
            end
        end else if (tick) begin
            case (ph_q)
                PH_ST_REL_SDA: ph_n = PH_ST_REL_SCL;
                PH_ST_REL_SCL: ph_n = PH_ST_FALL;
                PH_ST_FALL:    ph_n = PH_PREP;
                PH_PREP: begin
                    ph_n   = PH_BIT_LO;
                    bits_n = LAST_BIT;
                end
                PH_BIT_LO:     ph_n = PH_BIT_HI;
                PH_BIT_HI: begin
                    if (bits_q == '0) begin
                        ph_n = PH_ACK_LO;
                    end else begin
                        ph_n   = PH_BIT_LO;
                        sh_n   = {sh_q[BYTE_W-2:0], 1'b0};
                        bits_n = bits_q - 1'b1;
                    end
                end
                PH_ACK_LO:     ph_n = PH_ACK_HI;
                PH_ACK_HI:     ph_n = PH_IDLE;
                PH_SP_SCL_LO:  ph_n = PH_SP_SDA_LO;
                PH_SP_SDA_LO:  ph_n = PH_SP_SCL_HI;
                PH_SP_SCL_HI:  ph_n = PH_SP_RISE;
                PH_SP_RISE:    ph_n = PH_IDLE;
                default:       ph_n = PH_IDLE;
            endcase
        end
    end

    // line drive for the phase being entered
    always_comb begin
        drv_n = drv_q;
        case (ph_n)
            PH_IDLE: begin
                if (ph_q == PH_ACK_HI)
                    drv_n = '{scl: 1'b1, sda: 1'b0};
                else if (ph_q == PH_SP_RISE)
                    drv_n = '{scl: 1'b0, sda: 1'b0};
            end
            PH_ST_REL_SDA: drv_n = '{scl: drv_q.scl, sda: 1'b0};
            PH_ST_REL_SCL: drv_n = '{scl: 1'b0, sda: 1'b0};
            PH_ST_FALL:    drv_n = '{scl: 1'b0, sda: 1'b1};
            PH_PREP:       drv_n = '{scl: 1'b1, sda: drv_q.sda};
            PH_BIT_LO:     drv_n = '{scl: 1'b1, sda: ~sh_n[BYTE_W-1]};
            PH_BIT_HI:     drv_n = '{scl: 1'b0, sda: drv_q.sda};
            PH_ACK_LO:     drv_n = '{scl: 1'b1, sda: 1'b0};
            PH_ACK_HI:     drv_n = '{scl: 1'b0, sda: 1'b0};
            PH_SP_SCL_LO:  drv_n = '{scl: 1'b1, sda: drv_q.sda};
            PH_SP_SDA_LO:  drv_n = '{scl: 1'b1, sda: 1'b1};
            PH_SP_SCL_HI:  drv_n = '{scl: 1'b0, sda: 1'b1};
            PH_SP_RISE:    drv_n = '{scl: 1'b0, sda: 1'b0};
            default:       drv_n = drv_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            sh_q   <= '0;
            bits_q <= '0;
            drv_q  <= '0;
            done   <= 1'b1;
            ack    <= 1'b0;
        end else begin
            ph_q   <= ph_n;
            sh_q   <= sh_n;
            bits_q <= bits_n;
            drv_q  <= drv_n;
            if (launch)
                done <= 1'b0;
            else if (finish)
                done <= 1'b1;
            if (ph_q == PH_ACK_HI && tick)
                ack <= ~sda_i;
        end
    end

    // R2: an accepted launch drops done on the following cycle
    a_r2_launch_clears_done: assert property (@(posedge clk) disable iff (rst)
        launch |=> !done);

    // R2: done never reads 1 while a phase sequence is running
    a_r2_busy_not_done: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R4: with SCL high on both sides, SDA may move only as START or STOP
    a_r4_sda_steady_scl_high: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
            |-> (ph_q == PH_ST_FALL || ph_q == PH_SP_RISE));

    // R5: ack only moves at the ninth-clock sample point
    a_r5_ack_holds: assert property (@(posedge clk) disable iff (rst)
        !(ph_q == PH_ACK_HI && tick) |=> $stable(ack));

    // R6: after the STOP phase both lines are released
    a_r6_stop_releases: assert property (@(posedge clk) disable iff (rst)
        ($past(ph_q) == PH_SP_RISE && ph_q == PH_IDLE) |-> (!scl_oe && !sda_oe));

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
    import i2cm_pkg::*;
#(
    parameter int               REG_W     = 16,
    parameter int               BYTE_W    = 8,
    parameter logic [DIV_W-1:0] DIV_RESET = 16'd8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe
);

    logic              launch;
    act_e              action;
    logic [BYTE_W-1:0] tx_byte;
    logic [DIV_W-1:0]  half;
    logic              tick;
    logic              busy;
    logic              done;
    logic              ack;

    i2cm_regs #(
        .REG_W     (REG_W),
        .BYTE_W    (BYTE_W),
        .DIV_RESET (DIV_RESET)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .done    (done),
        .ack     (ack),
        .launch  (launch),
        .action  (action),
        .tx_byte (tx_byte),
        .half    (half)
    );

    i2cm_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (launch),
        .run  (busy),
        .half (half),
        .tick (tick)
    );

    i2cm_engine #(
        .BYTE_W (BYTE_W)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .action  (action),
        .tx_byte (tx_byte),
        .tick    (tick),
        .sda_i   (sda_i),
        .busy    (busy),
        .done    (done),
        .ack     (ack),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe)
    );

endmodule

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_INIT   = 5;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        sda_i;
    logic        scl_oe;
    logic        sda_oe;
    logic        slave_pull = 1'b0;
    logic        slave_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t_launch = 0;

    assign sda_i = ~(sda_oe | slave_pull);

    i2c_byte_master #(
        .REG_W     (16),
        .BYTE_W    (8),
        .DIV_RESET (16'(DIV_INIT))
    ) i_i2c_byte_master (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sda_i     (sda_i),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- reference model ----------------
    logic [2:0]  q[$];
    logic        m_done = 1'b1, m_ack = 1'b0, m_busy = 1'b0;
    logic        m_scl = 1'b0, m_sda = 1'b0, m_win = 1'b0;
    logic        m_isbyte = 1'b0, m_ackplan = 1'b0;
    logic [2:0]  m_ctrl = '0;
    logic [7:0]  m_txd = '0;
    logic [15:0] m_div = 16'(DIV_INIT);

    function automatic void push_seg(input logic s, input logic d, input logic w, input int h);
        for (int i = 0; i < h; i++) q.push_back({w, s, d});
    endfunction

    function automatic void build(input logic [7:0] data);
        int   h;
        logic cs, cd;
        h  = (m_div < 16'd4) ? 4 : int'(m_div);
        cs = m_scl;
        cd = m_sda;
        if (m_ctrl[2]) begin
            push_seg(1'b1, cd, 1'b0, h);
            push_seg(1'b1, 1'b1, 1'b0, h);
            push_seg(1'b0, 1'b1, 1'b0, h);
            push_seg(1'b0, 1'b0, 1'b0, h);
        end else begin
            if (m_ctrl[1]) begin
                push_seg(cs, 1'b0, 1'b0, h);
                push_seg(1'b0, 1'b0, 1'b0, h);
                push_seg(1'b0, 1'b1, 1'b0, h);
                cd = 1'b1;
            end
            push_seg(1'b1, cd, 1'b0, h);
            for (int b = 7; b >= 0; b--) begin
                push_seg(1'b1, ~data[b], 1'b0, h);
                push_seg(1'b0, ~data[b], 1'b0, h);
            end
            push_seg(1'b1, 1'b0, 1'b1, h);
            push_seg(1'b0, 1'b0, 1'b1, h);
        end
    endfunction

    always @(posedge clk) begin
        logic       was_done;
        logic [2:0] e;
        if (rst) begin
            q.delete();
            m_done = 1'b1; m_ack = 1'b0; m_busy = 1'b0;
            m_scl = 1'b0; m_sda = 1'b0; m_win = 1'b0;
            m_ctrl = '0; m_txd = '0; m_div = 16'(DIV_INIT);
        end else begin
            was_done = m_done;
            if (m_busy) begin
                if (q.size() > 0) begin
                    e = q.pop_front();
                    {m_win, m_scl, m_sda} = e;
                end else begin
                    m_busy = 1'b0;
                    m_done = 1'b1;
                    m_win  = 1'b0;
                    if (m_isbyte) begin
                        m_ack = m_ackplan;
                        {m_scl, m_sda} = 2'b10;
                    end else begin
                        {m_scl, m_sda} = 2'b00;
                    end
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: m_ctrl = reg_wdata[2:0];
                    2'd2: begin
                        m_txd = reg_wdata[7:0];
                        if (m_ctrl[0] && was_done) begin
                            m_isbyte  = !m_ctrl[2];
                            m_ackplan = slave_ack;
                            build(reg_wdata[7:0]);
                            e = q.pop_front();
                            {m_win, m_scl, m_sda} = e;
                            m_busy = 1'b1;
                            m_done = 1'b0;
                        end
                    end
                    2'd3: m_div = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    // slave acknowledges only inside the ninth-clock window
    always @(negedge clk) slave_pull <= m_win & m_ackplan;

    // ---------------- per-cycle comparison ----------------
    always @(posedge clk) begin
        logic [15:0] exp_rd;
        #(CLK_PERIOD/4);
        if (!rst) begin
            case (reg_addr)
                2'd0:    exp_rd = {13'b0, m_ctrl};
                2'd1:    exp_rd = {14'b0, m_ack, m_done};
                2'd2:    exp_rd = {8'b0, m_txd};
                default: exp_rd = m_div;
            endcase
            checks++;
            if ({scl_oe, sda_oe} !== {m_scl, m_sda}) begin
                errors++;
                $display("FAIL R3/R4/R6/R8 line drive at cycle %0d: actual scl_oe=%b sda_oe=%b expected %b %b",
                         cyc, scl_oe, sda_oe, m_scl, m_sda);
            end
            checks++;
            if (reg_rdata !== exp_rd) begin
                errors++;
                $display("FAIL R10/R2/R5 readback addr %0d at cycle %0d: actual %h expected %h",
                         reg_addr, cyc, reg_rdata, exp_rd);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 2'd1;
        t_launch  = cyc;
    endtask

    task automatic rd_reg(input logic [1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
        reg_addr = 2'd1;
    endtask

    task automatic wait_done(output int n);
        reg_addr = 2'd1;
        #1;
        while (reg_rdata[0] == 1'b0) begin
            @(negedge clk);
            #1;
        end
        n = cyc - t_launch;
    endtask

    task automatic run_byte(input logic [2:0] ctrl, input logic [7:0] d, input int expn, input string tag);
        int n;
        wr_reg(2'd0, 16'(ctrl));
        wr_reg(2'd2, 16'(d));
        #1;
        chk("R2 done cleared after launch", int'(reg_rdata[0]), 0);
        wait_done(n);
        chk(tag, n, expn);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual %0d cycles expected fewer", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int v;
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(2'd0, v); chk("R1 control after reset", v, 0);
        rd_reg(2'd1, v); chk("R1 status after reset", v, 1);
        rd_reg(2'd2, v); chk("R1 tx byte after reset", v, 0);
        rd_reg(2'd3, v); chk("R1 divider after reset", v, DIV_INIT);
        chk("R1 lines released", int'({scl_oe, sda_oe}), 0);

        // R10 map: status not writable, control keeps only its 3 bits
        wr_reg(2'd1, 16'hFFFF);
        rd_reg(2'd1, v); chk("R10 status write ignored", v, 1);
        wr_reg(2'd0, 16'hFFF8);
        rd_reg(2'd0, v); chk("R10 control upper bits read 0", v, 0);

        // R9 write while enable clear
        wr_reg(2'd2, 16'h00A5);
        repeat (12) @(negedge clk);
        #1;
        chk("R9 disabled write leaves done", int'(reg_rdata[1:0]), 1);
        chk("R9 disabled write leaves lines", int'({scl_oe, sda_oe}), 0);

        // R3 START + address byte, slave acknowledges
        slave_ack = 1'b1;
        run_byte(3'b011, 8'hA0, 22*DIV_INIT, "R3 start+byte length");
        rd_reg(2'd1, v); chk("R5 ack set by slave", v, 3);
        chk("R4 hold after byte scl low sda released", int'({scl_oe, sda_oe}), 2);

        // R4 plain byte, slave silent, with a busy write in the middle (R9)
        slave_ack = 1'b0;
        wr_reg(2'd0, 16'h0001);
        wr_reg(2'd2, 16'h005A);
        repeat (7) @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0033;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd1;
        wait_done(n);
        chk("R4 plain byte length, R9 busy write ignored", n, 19*DIV_INIT);
        rd_reg(2'd1, v); chk("R5 ack clear without slave", v, 1);

        // repeated START from a held bus, acknowledged
        slave_ack = 1'b1;
        run_byte(3'b011, 8'hA1, 22*DIV_INIT, "R3 repeated start length");
        run_byte(3'b001, 8'hC3, 19*DIV_INIT, "R4 second plain byte length");

        // R6 STOP with dummy data, ack kept
        slave_ack = 1'b0;
        run_byte(3'b101, 8'hFF, 4*DIV_INIT, "R6 stop length");
        rd_reg(2'd1, v); chk("R5 ack held through stop", v, 3);
        chk("R6 lines released after stop", int'({scl_oe, sda_oe}), 0);

        // R8 divider clamp and plain value
        wr_reg(2'd3, 16'd2);
        slave_ack = 1'b1;
        run_byte(3'b011, 8'h3C, 22*4, "R8 clamped half-period start+byte");
        run_byte(3'b101, 8'h00, 4*4, "R8 clamped half-period stop");
        wr_reg(2'd3, 16'd6);
        slave_ack = 1'b0;
        run_byte(3'b001, 8'h81, 19*6, "R8 half-period of 6 plain byte");
        rd_reg(2'd1, v); chk("R5 ack cleared by silent slave", v, 1);

        // R7 start and stop together acts as STOP
        run_byte(3'b111, 8'h00, 4*6, "R7 start+stop acts as stop");
        chk("R7 lines released", int'({scl_oe, sda_oe}), 0);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule